// File: doc/BRIEF.md
# SPI Word FIFO and Event Controller

This block sits between a 32-bit register bus and a word-level serial shift engine. It holds two eight-word queues. Words written by software at the data offset wait in the transmit queue until the engine takes them. Words delivered by the engine wait in the receive queue until software reads them at that same offset. Software sets a fill threshold for each queue and can empty either queue with a self-clearing flush. The control register carries both the thresholds and the flush bits.

Three sticky event flags are kept. Receive-complete is set when the receive level reaches its threshold. Transmit-complete is set when the transmit level drains to its threshold. Receive-overrun is set when the engine delivers a word into a full receive queue. The flags share one offset for reading and for write-one-to-clear. A single interrupt line is raised by any flag whose enable bit is set. Two single-word DMA request lines, each gated by its own enable bit, tell a DMA engine when one word can be moved in its direction.

Top module: `spi_fic_ctrl`

## Requirements
- R1: After a synchronous reset, the control, status and event registers all read 0, and `irq`, both DMA requests and `tx_word_valid` are low.
- R2: Words written at offset 4 are presented on `tx_word_data` in write order, one word per cycle in which `tx_word_valid` and `tx_word_ready` are both high. At most 8 are held, and a write while 8 are held is dropped.
- R3: Reading offset 4 returns the oldest received word one cycle after the read and removes it. A read while the receive queue is empty returns 0 and removes nothing.
- R4: A word delivered on `rx_word_valid` while the receive queue holds 8 words is discarded, and bit 0 of the event register (offset 3) is set and stays set until it is cleared.
- R5: A write to offset 0 loads the transmit threshold from bits 11:8 and the receive threshold from bits 3:0. If bit 12 is set it also empties the transmit queue, and if bit 4 is set it empties the receive queue, both by the next cycle. Reading offset 0 returns the thresholds, and the flush bits read as 0.
- R6: The status register (offset 1) reports bit 0 = receive queue not empty, bit 7 = busy (transmit queue not empty or `eng_busy` high), and bit 9 = receive level at or above a nonzero receive threshold.
- R7: Bit 3 of the event register is set when an accepted received word brings the receive level to or above a nonzero receive threshold. Bit 9 of the event register mirrors status bit 9.
- R8: Bit 4 of the event register is set when a word taken by the engine leaves the transmit level at or below the transmit threshold.
- R9: Writing 1 to bits 4, 3 or 0 at offset 3 clears the matching flag. A set event in the same cycle as its clear leaves the flag set.
- R10: `irq` is high when any of event bits 4, 3 and 0 is set together with the same bit of the enable register (offset 2).
- R11: `tx_dma_req` is high when enable bit 2 is set and the transmit queue is not full. `rx_dma_req` is high when enable bit 1 is set and the receive queue is not empty. Event register bits 2 and 1 show these two requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd_en` |
| tx_word_data | output | 32 | Oldest transmit word |
| tx_word_valid | output | 1 | Transmit queue holds a word |
| tx_word_ready | input | 1 | Engine takes the presented word |
| rx_word_data | input | 32 | Word delivered by the engine |
| rx_word_valid | input | 1 | Engine delivers a word this cycle |
| eng_busy | input | 1 | Engine is shifting |
| tx_dma_req | output | 1 | Transmit DMA single-word request |
| rx_dma_req | output | 1 | Receive DMA single-word request |
| irq | output | 1 | Combined interrupt |

## Verification
The event register can be written to clear the overrun flag in the same cycle that the engine delivers a word into a full receive queue, which sets that flag again. The bench fills the receive queue, clears every flag, and then drives the clear write and the overflowing delivery on the same edge. It then reads the event register and expects bit 0 still set and bit 3 still clear, because the dropped word is not an accepted push. Flush writes that land while both queues hold data are judged the same way, through the status bits and `tx_word_valid` one cycle later.

// File: rtl/spi_fic_pkg.sv
`timescale 1ns/1ps
package spi_fic_pkg;
  // register word offsets
  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_STAT = 1;
  localparam int unsigned OFS_IEN  = 2;
  localparam int unsigned OFS_EVT  = 3;
  localparam int unsigned OFS_DATA = 4;
  // control fields
  localparam int unsigned CB_TXTH    = 8;
  localparam int unsigned CB_RXTH    = 0;
  localparam int unsigned CB_TXFLUSH = 12;
  localparam int unsigned CB_RXFLUSH = 4;
  // event / enable bit positions
  localparam int unsigned EB_TXDONE = 4;
  localparam int unsigned EB_RXDONE = 3;
  localparam int unsigned EB_TXDMA  = 2;
  localparam int unsigned EB_RXDMA  = 1;
  localparam int unsigned EB_OVR    = 0;
  // status bit positions
  localparam int unsigned SB_RXTH = 9;
  localparam int unsigned SB_BUSY = 7;
  localparam int unsigned SB_RXNE = 0;
endpackage

// File: rtl/spi_fic_fifo.sv
`timescale 1ns/1ps
module spi_fic_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       full,
  output logic                       empty
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rptr];

  // storage has no reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  p_full_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> full && $stable(wptr));
  p_empty_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push && !flush) |=> empty && $stable(rptr));
  p_flush_clears_r5: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);
endmodule

// File: rtl/spi_fic_evt.sv
`timescale 1ns/1ps
module spi_fic_evt import spi_fic_pkg::*; #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_push_ok,
  input  logic [CW-1:0] rx_after,
  input  logic [CW-1:0] rx_th,
  input  logic          tx_pop_ok,
  input  logic [CW-1:0] tx_after,
  input  logic [CW-1:0] tx_th,
  input  logic          ovr_evt,
  input  logic          clr_wr,
  input  logic [4:0]    clr_bits,
  input  logic          ien_wr,
  input  logic [4:0]    ien_d,
  input  logic          tx_full,
  input  logic          rx_empty,
  output logic [4:0]    evt,
  output logic [4:0]    ien,
  output logic          irq,
  output logic          tx_dma_req,
  output logic          rx_dma_req
);
  logic f_txdone, f_rxdone, f_ovr;
  logic s_txdone, s_rxdone;
  logic [4:0] clr;

  assign s_rxdone = rx_push_ok && (rx_th != '0) && (rx_after >= rx_th);
  assign s_txdone = tx_pop_ok && (tx_after <= tx_th);
  assign clr      = clr_wr ? clr_bits : 5'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      f_txdone <= 1'b0;
      f_rxdone <= 1'b0;
      f_ovr    <= 1'b0;
      ien      <= '0;
    end else begin
      // a set in the same cycle as its clear wins
      f_txdone <= (f_txdone && !clr[EB_TXDONE]) || s_txdone;
      f_rxdone <= (f_rxdone && !clr[EB_RXDONE]) || s_rxdone;
      f_ovr    <= (f_ovr    && !clr[EB_OVR])    || ovr_evt;
      if (ien_wr) ien <= ien_d;
    end
  end

  assign tx_dma_req = ien[EB_TXDMA] && !tx_full;
  assign rx_dma_req = ien[EB_RXDMA] && !rx_empty;
  assign evt = {f_txdone, f_rxdone, tx_dma_req, rx_dma_req, f_ovr};
  assign irq = (f_txdone && ien[EB_TXDONE]) || (f_rxdone && ien[EB_RXDONE])
            || (f_ovr && ien[EB_OVR]);

  p_ovr_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (evt[EB_OVR] && !clr[EB_OVR]) |=> evt[EB_OVR]);
  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    ovr_evt |=> evt[EB_OVR]);
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (clr[EB_TXDONE] && !s_txdone) |=> !evt[EB_TXDONE]);
endmodule

// File: rtl/spi_fic_ctrl.sv
`timescale 1ns/1ps
module spi_fic_ctrl import spi_fic_pkg::*; #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr_en,
  input  logic          bus_rd_en,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] tx_word_data,
  output logic          tx_word_valid,
  input  logic          tx_word_ready,
  input  logic [DW-1:0] rx_word_data,
  input  logic          rx_word_valid,
  input  logic          eng_busy,
  output logic          tx_dma_req,
  output logic          rx_dma_req,
  output logic          irq
);
  localparam int unsigned CW = $clog2(DEPTH) + 1;

  logic [CW-1:0] tx_cnt, rx_cnt, tx_after, rx_after, tx_th, rx_th;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [DW-1:0] rx_head, rd_mux;
  logic          wr_ctrl, wr_data, wr_ien, wr_evt, rd_data;
  logic          tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok, rx_level_hit;
  logic [4:0]    evt, ien;

  assign wr_ctrl = bus_wr_en && (bus_addr == AW'(OFS_CTRL));
  assign wr_ien  = bus_wr_en && (bus_addr == AW'(OFS_IEN));
  assign wr_evt  = bus_wr_en && (bus_addr == AW'(OFS_EVT));
  assign wr_data = bus_wr_en && (bus_addr == AW'(OFS_DATA));
  assign rd_data = bus_rd_en && (bus_addr == AW'(OFS_DATA));

  spi_fic_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(wr_ctrl && bus_wdata[CB_TXFLUSH]),
    .push(wr_data), .din(bus_wdata), .pop(tx_word_ready),
    .head(tx_word_data), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  spi_fic_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(wr_ctrl && bus_wdata[CB_RXFLUSH]),
    .push(rx_word_valid), .din(rx_word_data), .pop(rd_data),
    .head(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  assign tx_word_valid = !tx_empty;
  assign tx_push_ok    = wr_data && !tx_full;
  assign tx_pop_ok     = tx_word_ready && !tx_empty;
  assign rx_push_ok    = rx_word_valid && !rx_full;
  assign rx_pop_ok     = rd_data && !rx_empty;
  assign tx_after      = tx_cnt + CW'(tx_push_ok) - CW'(tx_pop_ok);
  assign rx_after      = rx_cnt + CW'(rx_push_ok) - CW'(rx_pop_ok);
  assign rx_level_hit  = (rx_th != '0) && (rx_cnt >= rx_th);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_th <= '0;
      rx_th <= '0;
    end else if (wr_ctrl) begin
      tx_th <= bus_wdata[CB_TXTH +: CW];
      rx_th <= bus_wdata[CB_RXTH +: CW];
    end
  end

  spi_fic_evt #(.CW(CW)) u_evt (
    .clk(clk), .rst(rst),
    .rx_push_ok(rx_push_ok), .rx_after(rx_after), .rx_th(rx_th),
    .tx_pop_ok(tx_pop_ok), .tx_after(tx_after), .tx_th(tx_th),
    .ovr_evt(rx_word_valid && rx_full),
    .clr_wr(wr_evt), .clr_bits(bus_wdata[4:0]),
    .ien_wr(wr_ien), .ien_d(bus_wdata[4:0]),
    .tx_full(tx_full), .rx_empty(rx_empty),
    .evt(evt), .ien(ien), .irq(irq),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req));

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      AW'(OFS_CTRL): begin
        rd_mux[CB_TXTH +: CW] = tx_th;
        rd_mux[CB_RXTH +: CW] = rx_th;
      end
      AW'(OFS_STAT): begin
        rd_mux[SB_RXTH] = rx_level_hit;
        rd_mux[SB_BUSY] = !tx_empty || eng_busy;
        rd_mux[SB_RXNE] = !rx_empty;
      end
      AW'(OFS_IEN):  rd_mux[4:0] = ien;
      AW'(OFS_EVT): begin
        rd_mux[4:0]     = evt;
        rd_mux[SB_RXTH] = rx_level_hit;
      end
      AW'(OFS_DATA): rd_mux = rx_empty ? '0 : rx_head;
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            bus_rdata <= '0;
    else if (bus_rd_en) bus_rdata <= rd_mux;
  end

  p_rd_empty_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_data && rx_empty) |=> (bus_rdata == '0));
  p_txdma_room_r11: assert property (@(posedge clk) disable iff (rst)
    tx_dma_req |-> (tx_cnt != CW'(DEPTH)));
  p_rxdma_data_r11: assert property (@(posedge clk) disable iff (rst)
    rx_dma_req |-> (rx_cnt != '0));
  p_rx_ovr_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_word_valid && rx_full && !rd_data && !(wr_ctrl && bus_wdata[CB_RXFLUSH]))
      |=> (rx_cnt == CW'(DEPTH)) && evt[EB_OVR]);
endmodule

// File: tb/tb_spi_fic_ctrl.sv
`timescale 1ns/1ps
module tb_spi_fic_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] tx_word_data, rx_word_data = '0;
  logic        tx_word_valid, tx_word_ready = 1'b0, rx_word_valid = 1'b0;
  logic        eng_busy = 1'b0, tx_dma_req, rx_dma_req, irq;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] rv;

  // stimulus word (high half) and expected word seen at the far side (low half)
  localparam logic [63:0] VEC [8] = '{
    {32'hA5A5_0001, 32'hA5A5_0001}, {32'h0000_0000, 32'h0000_0000},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF}, {32'h1234_5678, 32'h1234_5678},
    {32'h8000_0000, 32'h8000_0000}, {32'h0000_0001, 32'h0000_0001},
    {32'hDEAD_BEEF, 32'hDEAD_BEEF}, {32'h5A5A_C3C3, 32'h5A5A_C3C3}};

  spi_fic_ctrl dut (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp=finish", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd_en = 1'b0; d = bus_rdata;
  endtask

  task automatic eng_push(input logic [31:0] d);
    @(negedge clk); rx_word_valid = 1'b1; rx_word_data = d;
    @(negedge clk); rx_word_valid = 1'b0;
  endtask

  task automatic eng_take(output logic [31:0] d);
    @(negedge clk); d = tx_word_data; tx_word_ready = 1'b1;
    @(negedge clk); tx_word_ready = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 dma", {30'b0, tx_dma_req, rx_dma_req}, 0);
    chk("R1 txvalid", {31'b0, tx_word_valid}, 0);
    rd(3'd0, rv); chk("R1 ctrl", rv, 0);
    rd(3'd1, rv); chk("R1 stat", rv, 0);
    rd(3'd3, rv); chk("R1 evt", rv, 0);

    // R5 thresholds tx=6 rx=2
    wr(3'd0, 32'h0602);
    rd(3'd0, rv); chk("R5 ctrl readback", rv, 32'h602);
    // R6 busy from engine
    eng_busy = 1'b1;
    rd(3'd1, rv); chk("R6 busy engine", rv, 32'h80);
    eng_busy = 1'b0;

    // R2 table through transmit queue
    for (int i = 0; i < 8; i++) wr(3'd4, VEC[i][63:32]);
    wr(3'd4, 32'hBAD0_BAD0);
    rd(3'd1, rv); chk("R6 busy txq", rv, 32'h80);
    for (int i = 0; i < 8; i++) begin
      eng_take(rv); chk("R2 tx order", rv, VEC[i][31:0]);
      if (i == 0) begin
        rd(3'd3, rv); chk("R8 not yet", rv & 32'h10, 0);
      end
    end
    chk("R2 drop on full", {31'b0, tx_word_valid}, 0);
    rd(3'd3, rv); chk("R8 txdone", rv & 32'h10, 32'h10);
    wr(3'd3, 32'h19);
    rd(3'd3, rv); chk("R9 clear all", rv, 0);

    // R3/R4/R7 receive path
    eng_push(VEC[0][63:32]);
    rd(3'd1, rv); chk("R6 rxne", rv, 32'h001);
    rd(3'd3, rv); chk("R7 below th", rv & 32'h08, 0);
    eng_push(VEC[1][63:32]);
    rd(3'd1, rv); chk("R6 level bit", rv, 32'h201);
    rd(3'd3, rv); chk("R7 rxdone", rv & 32'h08, 32'h08);
    for (int i = 2; i < 8; i++) eng_push(VEC[i][63:32]);
    eng_push(32'hBAD1_BAD1);
    rd(3'd3, rv); chk("R4 overrun", rv, 32'h209);
    for (int i = 0; i < 8; i++) begin
      rd(3'd4, rv); chk("R3 rx order", rv, VEC[i][31:0]);
    end
    rd(3'd4, rv); chk("R3 empty read", rv, 0);
    eng_push(32'h55);
    rd(3'd4, rv); chk("R3 no advance", rv, 32'h55);
    rd(3'd3, rv); chk("R4 sticky", rv, 32'h009);

    // R10 interrupt masking
    chk("R10 masked", {31'b0, irq}, 0);
    wr(3'd2, 32'h01); chk("R10 ovr en", {31'b0, irq}, 1);
    wr(3'd3, 32'h01); chk("R10 ovr clr", {31'b0, irq}, 0);
    wr(3'd2, 32'h08); chk("R10 rxdone en", {31'b0, irq}, 1);
    wr(3'd3, 32'h08); chk("R10 rxdone clr", {31'b0, irq}, 0);

    // R11 DMA requests
    wr(3'd2, 32'h06);
    chk("R11 tx room", {31'b0, tx_dma_req}, 1);
    chk("R11 rx empty", {31'b0, rx_dma_req}, 0);
    eng_push(32'h77);
    chk("R11 rx data", {31'b0, rx_dma_req}, 1);
    for (int i = 0; i < 8; i++) wr(3'd4, VEC[i][63:32]);
    chk("R11 tx full", {31'b0, tx_dma_req}, 0);
    wr(3'd2, 32'h00);
    chk("R11 disabled", {30'b0, tx_dma_req, rx_dma_req}, 0);

    // R5 flushes
    wr(3'd0, 32'h1602);
    chk("R5 tx flush", {31'b0, tx_word_valid}, 0);
    rd(3'd1, rv); chk("R5 rx kept", rv, 32'h001);
    wr(3'd0, 32'h0612);
    rd(3'd1, rv); chk("R5 rx flush", rv, 0);
    rd(3'd0, rv); chk("R5 flush bits 0", rv, 32'h602);

    // R9 set and clear in the same cycle
    for (int i = 0; i < 8; i++) eng_push(VEC[i][63:32]);
    wr(3'd3, 32'h19);
    rd(3'd3, rv); chk("R9 cleared", rv & 32'h19, 0);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = 3'd3; bus_wdata = 32'h01;
    rx_word_valid = 1'b1; rx_word_data = 32'hC0FF_EE00;
    @(negedge clk);
    bus_wr_en = 1'b0; rx_word_valid = 1'b0;
    rd(3'd3, rv); chk("R9 set wins", rv & 32'h19, 32'h01);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule